// File: doc/BRIEF.md
# Class-Selected 32-bit ALU

This combinational unit computes one 32-bit result from two operands and a small set of control fields. A two-bit class code picks one of four results. The first places a 16-bit immediate in the upper half of the word. The second is a signed less-than flag taken from the subtractor. The third is the adder/subtractor output. The fourth is a bitwise logic result. The second operand is either a register value or an immediate. Any sign or zero extension of the immediate is done upstream, before it reaches the unit.

A zero flag reports when the adder/subtractor output is all zeros. A branch unit uses it for equal and not-equal tests. The select logic drives the add/subtract bit high for those tests. The unit holds no state. A clock and reset are present only so that the internal assertions can sample.

Top module: `alu_core`

## Requirements
- R1: With class code 2'b00, the result equals {upperImm, 16'h0000}, and the operands have no effect on it.
- R2: With class code 2'b01 and the subtract bit set, the result is 32'd1 when opA is less than opB as signed two's-complement numbers, and 32'd0 otherwise.
- R3: The less-than flag of R2 is correct even when opA - opB overflows, for example opA = 32'h8000_0000 and opB = 32'h0000_0001 gives 1.
- R4: With class code 2'b10, the result is opA + opB when the subtract bit is 0, and opA - opB when it is 1, both modulo 2^32.
- R5: With class code 2'b11, the logic field selects the result: 2'b00 gives AND, 2'b01 gives OR, 2'b10 gives XOR, 2'b11 gives NOR.
- R6: zeroFlag is 1 exactly when the adder/subtractor output is all zeros, whatever the class code.
- R7: The logic field has no effect on the result when the class code is not 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the assertions only |
| rstN | input | 1 | Active-low reset that disables the assertions |
| fnClass | input | 2 | Result class: 00 upper immediate, 01 set-less, 10 arithmetic, 11 logic |
| subOp | input | 1 | 0 selects add, 1 selects subtract |
| logicFn | input | 2 | Logic function: 00 AND, 01 OR, 10 XOR, 11 NOR |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, either a register value or an extended immediate |
| upperImm | input | 16 | Immediate for the upper-half class |
| result | output | 32 | Selected result |
| zeroFlag | output | 1 | High when the adder/subtractor output is zero |

## Verification
Every output is purely combinational, so each result is due in the same cycle its inputs are applied, with no register in between. The bench drives new inputs on a falling clock edge. It then waits one nanosecond and samples result and zeroFlag well before the next rising edge. Checks therefore never depend on ordering at a clock edge. Expected values come from plain arithmetic on the applied operands, and each scenario task checks its own results.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DataW = 32;
  localparam int ImmW  = DataW / 2;

  typedef enum logic [1:0] {
    ClsUpper = 2'b00,
    ClsLess  = 2'b01,
    ClsArith = 2'b10,
    ClsLogic = 2'b11
  } fn_class_e;

  typedef enum logic [1:0] {
    LgAnd = 2'b00,
    LgOr  = 2'b01,
    LgXor = 2'b10,
    LgNor = 2'b11
  } logic_fn_e;

  typedef struct packed {
    logic      doSub;
    logic_fn_e lgSel;
    logic      pickUpper;
    logic      pickLess;
    logic      pickArith;
    logic      pickLogic;
  } alu_strobe_t;
endpackage

// File: rtl/alu_control.sv
module alu_control
  import alu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  fnClass,
  input  logic        subOp,
  input  logic [1:0]  logicFn,
  output alu_strobe_t strobes
);
  always_comb begin
    strobes           = '0;
    strobes.doSub     = subOp;
    strobes.lgSel     = logic_fn_e'(logicFn);
    unique case (fn_class_e'(fnClass))
      ClsUpper: strobes.pickUpper = 1'b1;
      ClsLess:  strobes.pickLess  = 1'b1;
      ClsArith: strobes.pickArith = 1'b1;
      default:  strobes.pickLogic = 1'b1;
    endcase
  end

  // Exactly one result class is selected (supports R1, R2, R4, R5)
  p_onehot_class_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.pickUpper, strobes.pickLess,
                strobes.pickArith, strobes.pickLogic}) == 1);
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W  = DataW,
  parameter int IW = ImmW
)(
  input  logic          clk,
  input  logic          rstN,
  input  alu_strobe_t   strobes,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [IW-1:0] upperImm,
  output logic [W-1:0]  result,
  output logic          zeroFlag
);
  localparam int LowW = W - IW;

  logic [W-1:0] bEff;
  logic [W:0]   sumWide;
  logic [W-1:0] sumOut;
  logic         lessFlag;
  logic [W-1:0] logicOut;
  logic [W-1:0] upperOut;

  assign bEff    = strobes.doSub ? ~opB : opB;
  assign sumWide = {1'b0, opA} + {1'b0, bEff} + {{W{1'b0}}, strobes.doSub};
  assign sumOut  = sumWide[W-1:0];

  // signed less-than: sign of the difference, corrected when the subtraction overflows
  assign lessFlag = (opA[W-1] != opB[W-1]) ? opA[W-1] : sumOut[W-1];

  assign upperOut = {upperImm, {LowW{1'b0}}};

  always_comb begin
    unique case (strobes.lgSel)
      LgAnd:   logicOut = opA & opB;
      LgOr:    logicOut = opA | opB;
      LgXor:   logicOut = opA ^ opB;
      default: logicOut = ~(opA | opB);
    endcase
  end

  always_comb begin
    result = logicOut;
    if (strobes.pickUpper)      result = upperOut;
    else if (strobes.pickLess)  result = {{(W-1){1'b0}}, lessFlag};
    else if (strobes.pickArith) result = sumOut;
  end

  assign zeroFlag = (sumOut == '0);

  // R1: the upper class leaves the low half at zero
  p_upper_low_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pickUpper |-> result[LowW-1:0] == '0);

  // R2: the set-less class gives 0 or 1 only
  p_less_bool_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pickLess |-> result[W-1:1] == '0);

  // R3: the less flag agrees with a signed comparison
  p_less_signed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pickLess && strobes.doSub) |-> result[0] == ($signed(opA) < $signed(opB)));

  // R4: the arithmetic class matches the reference sum or difference
  p_arith_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pickArith |-> result == (strobes.doSub ? opA - opB : opA + opB));

  // R6: the zero flag follows operand equality while subtracting
  p_zero_eq_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doSub |-> zeroFlag == (opA == opB));
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  fnClass,
  input  logic        subOp,
  input  logic [1:0]  logicFn,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [15:0] upperImm,
  output logic [31:0] result,
  output logic        zeroFlag
);
  alu_strobe_t strobes;

  alu_control uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .fnClass (fnClass),
    .subOp   (subOp),
    .logicFn (logicFn),
    .strobes (strobes)
  );

  alu_datapath #(.W(DataW), .IW(ImmW)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .upperImm (upperImm),
    .result   (result),
    .zeroFlag (zeroFlag)
  );

  // R7: outside the logic class, the logic field cannot steer the result
  p_logicfn_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fnClass != 2'b11 && $stable(fnClass) && $stable(subOp) && $stable(opA)
     && $stable(opB) && $stable(upperImm)) |-> $stable(result));
endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  fnClass = 2'b00;
  logic        subOp = 1'b0;
  logic [1:0]  logicFn = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] upperImm = '0;
  logic [31:0] result;
  logic        zeroFlag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  alu_core dut (
    .clk(clk), .rstN(rstN), .fnClass(fnClass), .subOp(subOp), .logicFn(logicFn),
    .opA(opA), .opB(opB), .upperImm(upperImm), .result(result), .zeroFlag(zeroFlag)
  );

  task automatic apply(input logic [1:0] c, input logic s, input logic [1:0] f,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] u);
    @(negedge clk);
    fnClass = c; subOp = s; logicFn = f; opA = a; opB = b; upperImm = u;
    #1;
  endtask

  task automatic expectRes(input string req, input logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s: result=%h expected=%h", req, result, exp);
    end
  endtask

  task automatic expectZero(input string req, input logic exp);
    checks++;
    if (zeroFlag !== exp) begin
      errors++;
      $display("FAIL %s: zeroFlag=%b expected=%b", req, zeroFlag, exp);
    end
  endtask

  task automatic testReset();
    apply(2'b00, 1'b0, 2'b00, 32'h0, 32'h0, 16'h0);
    expectRes("R1", 32'h0);
    expectZero("R6", 1'b1);
  endtask

  task automatic testUpper();
    apply(2'b00, 1'b0, 2'b00, 32'hDEAD_BEEF, 32'h1234_5678, 16'hABCD);
    expectRes("R1", 32'hABCD_0000);
    apply(2'b00, 1'b1, 2'b11, 32'hFFFF_FFFF, 32'h0, 16'h8001);
    expectRes("R1", 32'h8001_0000);
  endtask

  task automatic testLess();
    apply(2'b01, 1'b1, 2'b00, 32'd3, 32'd7, 16'h0);
    expectRes("R2", 32'd1);
    apply(2'b01, 1'b1, 2'b00, 32'd7, 32'd3, 16'h0);
    expectRes("R2", 32'd0);
    apply(2'b01, 1'b1, 2'b00, 32'd5, 32'd5, 16'h0);
    expectRes("R2", 32'd0);
    apply(2'b01, 1'b1, 2'b00, 32'hFFFF_FFFF, 32'd0, 16'h0);
    expectRes("R2", 32'd1);
  endtask

  task automatic testOverflow();
    apply(2'b01, 1'b1, 2'b00, 32'h8000_0000, 32'h0000_0001, 16'h0);
    expectRes("R3", 32'd1);
    apply(2'b01, 1'b1, 2'b00, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0);
    expectRes("R3", 32'd0);
    apply(2'b01, 1'b1, 2'b00, 32'h0000_0001, 32'h8000_0000, 16'h0);
    expectRes("R3", 32'd0);
  endtask

  task automatic testArith();
    apply(2'b10, 1'b0, 2'b00, 32'd100, 32'd23, 16'h0);
    expectRes("R4", 32'd123);
    apply(2'b10, 1'b1, 2'b00, 32'd100, 32'd23, 16'h0);
    expectRes("R4", 32'd77);
    apply(2'b10, 1'b0, 2'b00, 32'hFFFF_FFFF, 32'd1, 16'h0);
    expectRes("R4", 32'h0);
    apply(2'b10, 1'b1, 2'b00, 32'd0, 32'd1, 16'h0);
    expectRes("R4", 32'hFFFF_FFFF);
  endtask

  task automatic testLogic();
    logic [31:0] a, b;
    a = 32'hF0F0_1234; b = 32'h0FF0_5678;
    apply(2'b11, 1'b0, 2'b00, a, b, 16'h0);
    expectRes("R5", a & b);
    apply(2'b11, 1'b0, 2'b01, a, b, 16'h0);
    expectRes("R5", a | b);
    apply(2'b11, 1'b0, 2'b10, a, b, 16'h0);
    expectRes("R5", a ^ b);
    apply(2'b11, 1'b0, 2'b11, a, b, 16'h0);
    expectRes("R5", ~(a | b));
  endtask

  task automatic testZero();
    apply(2'b11, 1'b1, 2'b01, 32'h1234_5678, 32'h1234_5678, 16'h0);
    expectZero("R6", 1'b1);
    apply(2'b00, 1'b1, 2'b00, 32'h1234_5678, 32'h1234_5679, 16'h0);
    expectZero("R6", 1'b0);
    apply(2'b10, 1'b0, 2'b00, 32'h8000_0000, 32'h8000_0000, 16'h0);
    expectZero("R6", 1'b1);
  endtask

  task automatic testIgnored();
    for (int f = 0; f < 4; f++) begin
      apply(2'b10, 1'b0, f[1:0], 32'd40, 32'd2, 16'h0);
      expectRes("R7", 32'd42);
      apply(2'b01, 1'b1, f[1:0], 32'd1, 32'd2, 16'h0);
      expectRes("R7", 32'd1);
    end
  endtask

  initial begin
    #10000;
    errors++;
    $display("FAIL watchdog: timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testUpper();
    testLess();
    testOverflow();
    testArith();
    testLogic();
    testZero();
    testIgnored();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule